// File: doc/BRIEF.md
# Early-Terminating Iterative Multiply-Accumulate Unit

This unit serves the multiply instructions of a 32-bit RISC core. The core hands it an operation code, the multiplicand and multiplier values, up to two accumulator values and one or two destination register indices. The unit then works through the multiplier eight bits per cycle. It stops once the remaining upper bits of the multiplier are pure sign extension, meaning all zeros or all ones. Accumulation, and the fix-up that an unsigned long product needs, take a fixed number of extra cycles. The busy output therefore stays high for a number of cycles that depends on the data. When busy drops, the unit pulses done for one cycle. In that cycle it presents the result, the write enables for the low and high destinations, and the N and Z flags.

If the destination index is the program counter (index 15), the whole operation is dropped. Nothing is written, no flags change, and no multiply cycles are spent. The unit has no carry or overflow flag output, so C and V are always left to the core. A narrow form, used by the 16-bit instruction encoding, multiplies a register in place. It takes its early-termination count from that register and adds no extra cycles.

Top module: `mac_iter_unit`

## Requirements
- R1: Operation codes on `op_i` are: 0 = 32-bit multiply, 1 = 32-bit multiply-accumulate, 2 = unsigned 64-bit multiply, 3 = signed 64-bit multiply, 4 = unsigned 64-bit multiply-accumulate, 5 = signed 64-bit multiply-accumulate, 6 = narrow in-place multiply. Code 0 writes the low 32 bits of `src_m_i * src_s_i` to `res_lo_o`, with `we_lo_o` high and `we_hi_o` low.
- R2: The base cycle count comes from the multiplier `src_s_i`. It is 1 if bits 31:8 are all zero or all one. Otherwise it is 2 if bits 31:16 are. Otherwise it is 3 if bits 31:24 are. In all other cases it is 4.
- R3: Codes 0 and 6 add 0 extra cycles, codes 1, 2 and 3 add 1, and codes 4 and 5 add 2. An accepted start raises `busy_o` from the next cycle on, for exactly base plus extra cycles. `done_o` is high for the single cycle after busy falls.
- R4: A 32-bit form with `dst_lo_i` = 15 is suppressed. So is a 64-bit form with `dst_lo_i` = 15 or `dst_hi_i` = 15. Suppression means `busy_o` never rises, `done_o` pulses in the cycle after the start, and `we_lo_o`, `we_hi_o` and `flag_we_o` stay low.
- R5: Code 1 writes the low 32 bits of `src_m_i * src_s_i + acc_lo_i`.
- R6: Code 3 extends both operands with their sign to 64 bits, and code 2 extends both with zeros. The low half of the 64-bit product goes out on `res_lo_o` and the high half on `res_hi_o`, with both write enables high.
- R7: Codes 4 and 5 add `{acc_hi_i, acc_lo_i}` to the 64-bit product. The high half includes the carry out of the low half.
- R8: With `set_flags_i` high, `flag_we_o` pulses with done. N is bit 63 and Z means all 64 bits are zero for the long forms. For the other forms, N and Z are bit 31 and all 32 bits zero. With `set_flags_i` low, `flag_we_o` stays low.
- R9: Code 6 writes the low 32 bits of `src_m_i * src_s_i`. It takes the base count from `src_m_i` instead of `src_s_i` and adds no extra cycles.
- R10: A start raised while `busy_o` is high is ignored. The running operation completes unchanged, and no second operation follows it.
- R11: In the done cycle, `wb_lo_idx_o` and `wb_hi_idx_o` carry the destination indices captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when not busy |
| op_i | input | 3 | Operation code |
| set_flags_i | input | 1 | Request N/Z flag update |
| src_m_i | input | 32 | Multiplicand (in-place register for code 6) |
| src_s_i | input | 32 | Multiplier |
| acc_lo_i | input | 32 | Low accumulator value |
| acc_hi_i | input | 32 | High accumulator value |
| dst_lo_i | input | 4 | Low / 32-bit destination index |
| dst_hi_i | input | 4 | High destination index |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_lo_o | output | 32 | Low result word |
| res_hi_o | output | 32 | High result word |
| wb_lo_idx_o | output | 4 | Low destination index |
| wb_hi_idx_o | output | 4 | High destination index |
| we_lo_o | output | 1 | Low destination write enable |
| we_hi_o | output | 1 | High destination write enable |
| flag_we_o | output | 1 | N/Z flag write enable |
| flag_n_o | output | 1 | Negative flag value |
| flag_z_o | output | 1 | Zero flag value |

## Verification
The cycle that reports one result is also the cycle in which the core may issue the next start. Handing off one result and accepting the next operation can therefore happen on the same edge. The sweep provokes this by launching every operation in the done cycle of the one before it. Each reported result, index and flag is judged against a full-width product computed in the bench, and each following busy length against the cycle-count rule. A start raised in the middle of a busy window checks the other overlap: the running result must come out unchanged, and no phantom operation may follow.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_UMULL = 3'd2,
    OP_SMULL = 3'd3,
    OP_UMLAL = 3'd4,
    OP_SMLAL = 3'd5,
    OP_NMUL  = 3'd6,
    OP_RSVD  = 3'd7
  } mac_op_e;

  function automatic logic op_is_long(mac_op_e op);
    return (op == OP_UMULL) || (op == OP_SMULL) ||
           (op == OP_UMLAL) || (op == OP_SMLAL);
  endfunction

  function automatic logic op_is_signed_long(mac_op_e op);
    return (op == OP_SMULL) || (op == OP_SMLAL);
  endfunction

  function automatic logic op_is_unsigned_long(mac_op_e op);
    return (op == OP_UMULL) || (op == OP_UMLAL);
  endfunction

  function automatic logic op_is_long_acc(mac_op_e op);
    return (op == OP_UMLAL) || (op == OP_SMLAL);
  endfunction

endpackage

// File: rtl/mac_latency.sv
module mac_latency
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8,
  parameter int CNT_W   = 3
) (
  input  logic [DATA_W-1:0] mult_i,
  input  mac_op_e           op_i,
  output logic [CNT_W-1:0]  base_o,
  output logic [CNT_W-1:0]  extra_o,
  output logic              neg_top_o
);

  localparam int NDIG = DATA_W / DIGIT_W;

  // fit_zero[k]/fit_ones[k]: bits above the lowest k digits are all 0 / all 1
  logic [NDIG-1:1] fit_zero;
  logic [NDIG-1:1] fit_ones;

  genvar k;
  generate
    for (k = 1; k < NDIG; k++) begin : g_fit
      assign fit_zero[k] = ~|mult_i[DATA_W-1:k*DIGIT_W];
      assign fit_ones[k] =  &mult_i[DATA_W-1:k*DIGIT_W];
    end
  endgenerate

  // smallest digit count whose upper remainder is pure sign extension
  always_comb begin
    base_o    = CNT_W'(NDIG);
    neg_top_o = op_is_signed_long(op_i) & mult_i[DATA_W-1];
    for (int j = NDIG - 1; j >= 1; j--) begin
      if (fit_zero[j] || fit_ones[j]) begin
        base_o    = CNT_W'(j);
        neg_top_o = ~fit_zero[j];
      end
    end
  end

  always_comb begin
    case (op_i)
      OP_MLA, OP_UMULL, OP_SMULL: extra_o = CNT_W'(1);
      OP_UMLAL, OP_SMLAL:         extra_o = CNT_W'(2);
      default:                    extra_o = '0;
    endcase
  end

endmodule

// File: rtl/mac_digit_step.sv
module mac_digit_step #(
  parameter int PROD_W  = 64,
  parameter int DIGIT_W = 8
) (
  input  logic [PROD_W-1:0]  acc_i,
  input  logic [PROD_W-1:0]  mcand_i,
  input  logic [DIGIT_W-1:0] digit_i,
  input  logic               neg_i,
  output logic [PROD_W-1:0]  sum_o
);

  // neg_i turns the digit into (digit - 2**DIGIT_W)
  logic [PROD_W-1:0] digit_ext;
  logic [PROD_W-1:0] partial;

  assign digit_ext = {{(PROD_W-DIGIT_W){neg_i}}, digit_i};
  assign partial   = $unsigned($signed(mcand_i) * $signed(digit_ext));
  assign sum_o     = acc_i + partial;

endmodule

// File: rtl/mac_flag_gen.sv
module mac_flag_gen #(
  parameter int DATA_W = 32
) (
  input  logic [2*DATA_W-1:0] result_i,
  input  logic                long_i,
  output logic                n_o,
  output logic                z_o
);

  always_comb begin
    if (long_i) begin
      n_o = result_i[2*DATA_W-1];
      z_o = ~|result_i;
    end else begin
      n_o = result_i[DATA_W-1];
      z_o = ~|result_i[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/mac_iter_unit.sv
module mac_iter_unit
  import mac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8,
  parameter int IDX_W   = 4,
  parameter int PC_IDX  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] src_m_i,
  input  logic [DATA_W-1:0] src_s_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic [IDX_W-1:0]  dst_lo_i,
  input  logic [IDX_W-1:0]  dst_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [IDX_W-1:0]  wb_lo_idx_o,
  output logic [IDX_W-1:0]  wb_hi_idx_o,
  output logic              we_lo_o,
  output logic              we_hi_o,
  output logic              flag_we_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);

  localparam int NDIG   = DATA_W / DIGIT_W;
  localparam int PROD_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(NDIG + 3);

  mac_op_e op_in;
  assign op_in = mac_op_e'(op_i);

  // ---------------- operand routing at the start ----------------
  logic [DATA_W-1:0] mplier_in;
  logic [DATA_W-1:0] mcand_in;
  logic              suppress_in;
  logic [CNT_W-1:0]  base_in;
  logic [CNT_W-1:0]  extra_in;
  logic              neg_top_in;
  logic [PROD_W-1:0] mcand_ext_in;
  logic [PROD_W-1:0] addend_in;

  always_comb begin
    if (op_in == OP_NMUL) begin
      mplier_in = src_m_i;
      mcand_in  = src_s_i;
    end else begin
      mplier_in = src_s_i;
      mcand_in  = src_m_i;
    end
    if (op_is_long(op_in))
      suppress_in = (dst_lo_i == IDX_W'(PC_IDX)) || (dst_hi_i == IDX_W'(PC_IDX));
    else
      suppress_in = (dst_lo_i == IDX_W'(PC_IDX));
    if (op_is_signed_long(op_in))
      mcand_ext_in = {{DATA_W{mcand_in[DATA_W-1]}}, mcand_in};
    else
      mcand_ext_in = {{DATA_W{1'b0}}, mcand_in};
    if (op_is_long_acc(op_in))
      addend_in = {acc_hi_i, acc_lo_i};
    else if (op_in == OP_MLA)
      addend_in = {{DATA_W{1'b0}}, acc_lo_i};
    else
      addend_in = '0;
  end

  mac_latency #(
    .DATA_W  (DATA_W),
    .DIGIT_W (DIGIT_W),
    .CNT_W   (CNT_W)
  ) i_latency (
    .mult_i    (mplier_in),
    .op_i      (op_in),
    .base_o    (base_in),
    .extra_o   (extra_in),
    .neg_top_o (neg_top_in)
  );

  // ---------------- state ----------------
  logic              busy_q,     busy_d;
  logic              done_q,     done_d;
  logic [CNT_W-1:0]  left_q,     left_d;
  logic [CNT_W-1:0]  dig_left_q, dig_left_d;
  logic              ext_idx_q,  ext_idx_d;
  logic              neg_q,      neg_d;
  logic              corr_q,     corr_d;
  mac_op_e           op_q,       op_d;
  logic              sf_q,       sf_d;
  logic              supp_q,     supp_d;
  logic [IDX_W-1:0]  dlo_q,      dlo_d;
  logic [IDX_W-1:0]  dhi_q,      dhi_d;
  logic [PROD_W-1:0] acc_q,      acc_d;
  logic [PROD_W-1:0] mcand_q,    mcand_d;
  logic [DATA_W-1:0] mult_q,     mult_d;
  logic [DATA_W-1:0] orig_q,     orig_d;
  logic [PROD_W-1:0] addend_q,   addend_d;

  logic              accept;
  logic              state_en;
  logic [PROD_W-1:0] step_sum;
  logic [PROD_W-1:0] corr_term;

  assign accept   = start_i & ~busy_q;
  assign state_en = accept | busy_q | done_q;

  mac_digit_step #(
    .PROD_W  (PROD_W),
    .DIGIT_W (DIGIT_W)
  ) i_step (
    .acc_i   (acc_q),
    .mcand_i (mcand_q),
    .digit_i (mult_q[DIGIT_W-1:0]),
    .neg_i   (neg_q & (dig_left_q == CNT_W'(1))),
    .sum_o   (step_sum)
  );

  assign corr_term = corr_q ? {orig_q, {DATA_W{1'b0}}} : '0;

  // ---------------- next state ----------------
  always_comb begin
    busy_d     = busy_q;
    done_d     = 1'b0;
    left_d     = left_q;
    dig_left_d = dig_left_q;
    ext_idx_d  = ext_idx_q;
    neg_d      = neg_q;
    corr_d     = corr_q;
    op_d       = op_q;
    sf_d       = sf_q;
    supp_d     = supp_q;
    dlo_d      = dlo_q;
    dhi_d      = dhi_q;
    acc_d      = acc_q;
    mcand_d    = mcand_q;
    mult_d     = mult_q;
    orig_d     = orig_q;
    addend_d   = addend_q;
    if (accept) begin
      op_d       = op_in;
      sf_d       = set_flags_i;
      supp_d     = suppress_in;
      dlo_d      = dst_lo_i;
      dhi_d      = dst_hi_i;
      acc_d      = '0;
      mcand_d    = mcand_ext_in;
      mult_d     = mplier_in;
      orig_d     = mcand_in;
      addend_d   = addend_in;
      neg_d      = neg_top_in;
      corr_d     = op_is_unsigned_long(op_in) & neg_top_in;
      dig_left_d = base_in;
      ext_idx_d  = 1'b0;
      if (suppress_in) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        left_d = '0;
      end else begin
        busy_d = 1'b1;
        left_d = base_in + extra_in;
      end
    end else if (busy_q) begin
      left_d = left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
      if (dig_left_q != '0) begin
        acc_d      = step_sum;
        mcand_d    = mcand_q << DIGIT_W;
        mult_d     = mult_q >> DIGIT_W;
        dig_left_d = dig_left_q - CNT_W'(1);
      end else begin
        ext_idx_d = 1'b1;
        if (!ext_idx_q && op_is_long(op_q))
          acc_d = acc_q + corr_term;
        else
          acc_d = acc_q + addend_q;
      end
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      left_q     <= '0;
      dig_left_q <= '0;
      ext_idx_q  <= 1'b0;
      neg_q      <= 1'b0;
      corr_q     <= 1'b0;
      op_q       <= OP_MUL;
      sf_q       <= 1'b0;
      supp_q     <= 1'b0;
      dlo_q      <= '0;
      dhi_q      <= '0;
      acc_q      <= '0;
      mcand_q    <= '0;
      mult_q     <= '0;
      orig_q     <= '0;
      addend_q   <= '0;
    end else if (state_en) begin
      busy_q     <= busy_d;
      done_q     <= done_d;
      left_q     <= left_d;
      dig_left_q <= dig_left_d;
      ext_idx_q  <= ext_idx_d;
      neg_q      <= neg_d;
      corr_q     <= corr_d;
      op_q       <= op_d;
      sf_q       <= sf_d;
      supp_q     <= supp_d;
      dlo_q      <= dlo_d;
      dhi_q      <= dhi_d;
      acc_q      <= acc_d;
      mcand_q    <= mcand_d;
      mult_q     <= mult_d;
      orig_q     <= orig_d;
      addend_q   <= addend_d;
    end
  end

  // ---------------- outputs ----------------
  mac_flag_gen #(
    .DATA_W (DATA_W)
  ) i_flags (
    .result_i (acc_q),
    .long_i   (op_is_long(op_q)),
    .n_o      (flag_n_o),
    .z_o      (flag_z_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign res_lo_o    = acc_q[DATA_W-1:0];
  assign res_hi_o    = acc_q[PROD_W-1:DATA_W];
  assign wb_lo_idx_o = dlo_q;
  assign wb_hi_idx_o = dhi_q;
  assign we_lo_o     = done_q & ~supp_q;
  assign we_hi_o     = done_q & ~supp_q & op_is_long(op_q);
  assign flag_we_o   = done_q & ~supp_q & sf_q;

  // ---------------- assertions ----------------
  // R3: the busy window always ends in a done pulse
  p_fall_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R3: done lasts one cycle unless a new suppressed start lands on it
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start_i |=> !done_q);

  // R3: the remaining-cycle counter steps down by one while busy
  p_countdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (left_q > CNT_W'(1)) |=> busy_q && (left_q == $past(left_q) - CNT_W'(1)));

  // R2: the digit steps always fit in the remaining busy cycles
  p_digits_fit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> left_q >= dig_left_q);

  // R4: a suppressed start reports at once and writes nothing
  p_supp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && suppress_in |=> !busy_o && done_o && !we_lo_o && !we_hi_o && !flag_we_o);

  // R6: a high-half write never comes without the low-half write
  p_hi_with_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_hi_o |-> we_lo_o);

endmodule

// File: tb/test_mac_iter_unit.sv
module test_mac_iter_unit;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [2:0]  op_i;
  logic        set_flags_i;
  logic [31:0] src_m_i, src_s_i, acc_lo_i, acc_hi_i;
  logic [3:0]  dst_lo_i, dst_hi_i;
  logic        busy_o, done_o;
  logic [31:0] res_lo_o, res_hi_o;
  logic [3:0]  wb_lo_idx_o, wb_hi_idx_o;
  logic        we_lo_o, we_hi_o, flag_we_o, flag_n_o, flag_z_o;

  int total = 0;
  int bad   = 0;

  mac_iter_unit i_mac_iter_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .set_flags_i(set_flags_i), .src_m_i(src_m_i), .src_s_i(src_s_i),
    .acc_lo_i(acc_lo_i), .acc_hi_i(acc_hi_i), .dst_lo_i(dst_lo_i),
    .dst_hi_i(dst_hi_i), .busy_o(busy_o), .done_o(done_o),
    .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .wb_lo_idx_o(wb_lo_idx_o),
    .wb_hi_idx_o(wb_hi_idx_o), .we_lo_o(we_lo_o), .we_hi_o(we_hi_o),
    .flag_we_o(flag_we_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] val(input int i);
    case (i)
      0: return 32'h0000_0000;   1: return 32'h0000_0001;
      2: return 32'h0000_00FF;   3: return 32'h0000_0100;
      4: return 32'hFFFF_FF00;   5: return 32'hFFFF_FF80;
      6: return 32'h0000_FFFF;   7: return 32'h0001_0000;
      8: return 32'hFFFF_8000;   9: return 32'h8000_0000;
      10: return 32'h7FFF_FFFF;  11: return 32'hFFFF_FFFF;
      12: return 32'hFF00_0000;  default: return 32'h00FF_FFFF;
    endcase
  endfunction

  function automatic int exp_base(input logic [31:0] r);
    if (r[31:8] == 24'h0 || r[31:8] == 24'hFFFFFF) return 1;
    if (r[31:16] == 16'h0 || r[31:16] == 16'hFFFF) return 2;
    if (r[31:24] == 8'h0 || r[31:24] == 8'hFF) return 3;
    return 4;
  endfunction

  function automatic int exp_extra(input logic [2:0] op);
    case (op)
      3'd1, 3'd2, 3'd3: return 1;
      3'd4, 3'd5:       return 2;
      default:          return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_res(input logic [2:0] op, input logic [31:0] m, s, alo, ahi);
    logic signed [63:0] sm, ss;
    logic [63:0] um, us;
    sm = {{32{m[31]}}, m}; ss = {{32{s[31]}}, s};
    um = {32'h0, m};       us = {32'h0, s};
    case (op)
      3'd1: return um * us + {32'h0, alo};
      3'd2: return um * us;
      3'd3: return $unsigned(sm * ss);
      3'd4: return um * us + {ahi, alo};
      3'd5: return $unsigned(sm * ss) + {ahi, alo};
      default: return um * us;
    endcase
  endfunction

  // Launch an operation: called just after a falling edge, returns after the accepting edge.
  task automatic launch(input logic [2:0] op, input logic [31:0] m, s, alo, ahi,
                        input logic [3:0] dlo, dhi, input bit sf);
    op_i = op; src_m_i = m; src_s_i = s; acc_lo_i = alo; acc_hi_i = ahi;
    dst_lo_i = dlo; dst_hi_i = dhi; set_flags_i = sf; start_i = 1'b1;
    @(posedge clk);
  endtask

  // Count busy cycles up to done; optionally raise a second start mid-way (R10).
  task automatic wait_done(input bit intrude, output int lat);
    lat = 0;
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start_i = 1'b0;
        if (intrude && busy_o) begin
          start_i = 1'b1; op_i = 3'd0; src_m_i = 32'h5; src_s_i = 32'h7;
          dst_lo_i = 4'd1; set_flags_i = 1'b0;
        end
      end else begin
        start_i = 1'b0;
      end
      if (done_o) return;
      if (busy_o) lat++;
    end
    check(1'b0, "R3 done never seen", 64'(lat), 64'd0);
  endtask

  task automatic run_check(input logic [2:0] op, input logic [31:0] m, s, alo, ahi,
                           input logic [3:0] dlo, dhi, input bit sf, input bit intrude);
    int lat, elat;
    bit lng, supp;
    logic [63:0] r;
    lng  = (op >= 3'd2) && (op <= 3'd5);
    supp = lng ? (dlo == 4'd15 || dhi == 4'd15) : (dlo == 4'd15);
    elat = supp ? 0 : exp_base(op == 3'd6 ? m : s) + exp_extra(op);
    r    = exp_res(op, m, s, alo, ahi);
    launch(op, m, s, alo, ahi, dlo, dhi, sf);
    wait_done(intrude, lat);
    if (supp) begin
      check(lat == 0, "R4 latency", 64'(lat), 64'd0);
      check(!we_lo_o && !we_hi_o && !flag_we_o, "R4 write enables",
            {61'h0, we_lo_o, we_hi_o, flag_we_o}, 64'h0);
      return;
    end
    if (op == 3'd6) check(lat == elat, "R9 latency", 64'(lat), 64'(elat));
    else            check(lat == elat, "R2 R3 latency", 64'(lat), 64'(elat));
    case (op)
      3'd0: check(res_lo_o == r[31:0], "R1 mul result", {32'h0, res_lo_o}, {32'h0, r[31:0]});
      3'd1: check(res_lo_o == r[31:0], "R5 mla result", {32'h0, res_lo_o}, {32'h0, r[31:0]});
      3'd6: check(res_lo_o == r[31:0], "R9 narrow result", {32'h0, res_lo_o}, {32'h0, r[31:0]});
      3'd2, 3'd3: check({res_hi_o, res_lo_o} == r, "R6 long result", {res_hi_o, res_lo_o}, r);
      default: check({res_hi_o, res_lo_o} == r, "R7 long acc result", {res_hi_o, res_lo_o}, r);
    endcase
    check(we_lo_o && (we_hi_o == lng), "R1 R6 write enables", {62'h0, we_lo_o, we_hi_o}, {62'h0, 1'b1, lng});
    check(wb_lo_idx_o == dlo && wb_hi_idx_o == dhi, "R11 indices",
          {56'h0, wb_hi_idx_o, wb_lo_idx_o}, {56'h0, dhi, dlo});
    check(flag_we_o == sf, "R8 flag enable", {63'h0, flag_we_o}, {63'h0, sf});
    if (sf) begin
      if (lng) check(flag_n_o == r[63] && flag_z_o == (r == 64'h0), "R8 long flags",
                     {62'h0, flag_n_o, flag_z_o}, {62'h0, r[63], (r == 64'h0)});
      else     check(flag_n_o == r[31] && flag_z_o == (r[31:0] == 32'h0), "R8 short flags",
                     {62'h0, flag_n_o, flag_z_o}, {62'h0, r[31], (r[31:0] == 32'h0)});
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; op_i = '0; set_flags_i = 1'b0;
    src_m_i = '0; src_s_i = '0; acc_lo_i = '0; acc_hi_i = '0;
    dst_lo_i = '0; dst_hi_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && !we_lo_o && !we_hi_o && !flag_we_o, "R3 reset state",
          {59'h0, busy_o, done_o, we_lo_o, we_hi_o, flag_we_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: each operation launched in the done cycle of the previous one
    for (int op = 0; op < 7; op++)
      for (int i = 0; i < 14; i++)
        for (int j = 0; j < 14; j++)
          run_check(3'(op), val(i), val(j), val((i + 3) % 14), val((j + 5) % 14),
                    4'((i + j) % 15), 4'((i + 2 * j + 1) % 15), bit'((i + j) % 2), 1'b0);

    // R4: program-counter destinations
    run_check(3'd0, 32'h1234_5678, 32'h8765_4321, 0, 0, 4'd15, 4'd2, 1'b1, 1'b0);
    run_check(3'd2, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 4'd3, 4'd15, 1'b1, 1'b0);
    run_check(3'd5, 32'h0000_00FF, 32'h0001_0000, 1, 2, 4'd15, 4'd4, 1'b1, 1'b0);
    run_check(3'd1, 32'h0000_0003, 32'h0000_0004, 5, 0, 4'd15, 4'd15, 1'b0, 1'b0);

    // R10: a second start during busy is ignored
    run_check(3'd5, 32'h8000_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
              4'd6, 4'd9, 1'b1, 1'b1);
    @(negedge clk);
    check(!done_o && !busy_o, "R10 no phantom operation", {62'h0, done_o, busy_o}, 64'h0);
    @(negedge clk);
    check(!done_o && !busy_o, "R10 still idle", {62'h0, done_o, busy_o}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule